// File: doc/BRIEF.md
# Flash Block Write-Protection Controller

This block guards program and erase operations in a NAND-style flash command front end. Command and address cycles arrive on a byte-wide bus. From them the controller builds a single contiguous window of unlocked blocks. A global lock-tight flag freezes that window. Every block outside the window is locked.

A program or erase request names a target block and is checked against this state. A request aimed at an unlocked block is granted with a one-cycle pulse. A request aimed at any other block does nothing and drops the ready output for a fixed number of cycles. A lock-status query returns one status byte for a chosen block. Lock-tight can only be removed by driving the hardware write-protect input low.

Block addresses are `ADDR_BYTES` bytes wide and are sent least significant byte first. The default is two bytes, which gives 65536 blocks.

Top module: `flash_wp_guard`

## Requirements
- R1: After reset the ready output is high, opGrant is low, dataOut is 0, and a lock-status query of any block returns 0x02 (locked).
- R2: An unlock is entered as command 0x23, `ADDR_BYTES` start-address bytes, command 0x24, then `ADDR_BYTES` end-address bytes. The new window takes effect on the clock edge that takes the last end byte. Any other command written part-way through the sequence abandons it, and the window stays as it was.
- R3: Only one window exists. A completed unlock replaces the previous window, so blocks outside the new one become locked. When start equals end, exactly one block is unlocked. When start is greater than end, the sequence is discarded and the previous window remains.
- R4: Command 0x2C sets lock-tight. While lock-tight is set, unlock sequences have no effect. Blocks already inside the window stay unlocked, and requests to them are still granted.
- R5: No command clears lock-tight. On any clock edge that samples wpN low, lock-tight is cleared, the window is emptied, and every block is locked.
- R6: A request (opReq high while ready is high) is handled as follows. For an unlocked block, opGrant pulses high for one cycle after the edge and ready stays high. For any other block, opGrant stays low and ready is low for exactly `BUSY_CYC` cycles. A request made while ready is low is ignored.
- R7: Command 0x7A followed by `ADDR_BYTES` address bytes enters lock-status mode. While rdEn is high in that mode, dataOut carries the status byte of the chosen block: 0x04 if unlocked, 0x01 if locked under lock-tight, 0x02 if locked otherwise. In every other case dataOut is 0.
- R8: Lock-status mode persists across reads without any strobe toggling, and it tracks state changes live. Any later command ends it.
- R9: A 0x7A command written while ready is low is not accepted: the mode is not entered, and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdLatch | input | 1 | ioIn carries a command byte this cycle |
| addrLatch | input | 1 | ioIn carries an address byte this cycle |
| ioIn | input | 8 | Command or address byte |
| rdEn | input | 1 | Read cycle strobe |
| dataOut | output | 8 | Status byte during lock-status reads, else 0 |
| opReq | input | 1 | Program or erase request |
| opBlk | input | 8*ADDR_BYTES | Target block of the request |
| opGrant | output | 1 | One-cycle pulse: request allowed |
| ready | output | 1 | High when not busy |
| wpN | input | 1 | Hardware write-protect, active low |

## Verification
The bench targets the window edges: the first and last blocks of a range, and their outside neighbours. A comparison off by one would report the wrong status at exactly these blocks. It also checks a single-block window and a reversed start/end pair. A design without an ordering guard would unlock nothing or wrap around on the reversed pair. Unlock attempts under lock-tight, and a sequence broken by a stray command, are both made. A design that ignores either case would visibly move the window. The busy window is counted cycle by cycle, so an off-by-one counter shows up. Status queries issued while busy must read 0. A write-protect pulse made while the bench sits in status mode must change the live byte without a new query.

// File: rtl/wpg_pkg.sv
`timescale 1ns/1ps
package wpg_pkg;

  parameter logic [7:0] CMD_UL_START = 8'h23;
  parameter logic [7:0] CMD_UL_END   = 8'h24;
  parameter logic [7:0] CMD_TIGHT    = 8'h2C;
  parameter logic [7:0] CMD_STATUS   = 8'h7A;

  parameter logic [7:0] STS_TIGHT    = 8'h01;
  parameter logic [7:0] STS_LOCKED   = 8'h02;
  parameter logic [7:0] STS_UNLOCKED = 8'h04;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UL_LO,
    ST_UL_MID,
    ST_UL_HI,
    ST_QRY,
    ST_STS
  } wpg_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic loadQry;
    logic commit;
    logic setTight;
  } wpg_strobe_t;

endpackage

// File: rtl/wpg_ctrl.sv
`timescale 1ns/1ps
module wpg_ctrl
  import wpg_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdLatch,
  input  logic             addrLatch,
  input  logic [7:0]       ioIn,
  input  logic             ready,
  output wpg_strobe_t      stb,
  output logic [IDX_W-1:0] byteIdx,
  output logic             stsMode
);

  wpg_state_e st, stNext;
  logic [IDX_W-1:0] idxNext;
  logic lastByte;

  assign lastByte = (byteIdx == IDX_W'(ADDR_BYTES - 1));
  assign stsMode  = (st == ST_STS);

  always_comb begin
    stb     = '0;
    stNext  = st;
    idxNext = byteIdx;
    if (cmdLatch) begin
      idxNext = '0;
      case (ioIn)
        CMD_UL_START: stNext = ST_UL_LO;
        CMD_UL_END:   stNext = (st == ST_UL_MID) ? ST_UL_HI : ST_IDLE;
        CMD_TIGHT: begin
          stb.setTight = 1'b1;
          stNext       = ST_IDLE;
        end
        CMD_STATUS:   stNext = ready ? ST_QRY : ST_IDLE;
        default:      stNext = ST_IDLE;
      endcase
    end else if (addrLatch) begin
      case (st)
        ST_UL_LO: begin
          stb.loadLo = 1'b1;
          idxNext    = byteIdx + 1'b1;
          if (lastByte) begin
            stNext  = ST_UL_MID;
            idxNext = '0;
          end
        end
        ST_UL_HI: begin
          stb.loadHi = 1'b1;
          idxNext    = byteIdx + 1'b1;
          if (lastByte) begin
            stb.commit = 1'b1;
            stNext     = ST_IDLE;
            idxNext    = '0;
          end
        end
        ST_QRY: begin
          stb.loadQry = 1'b1;
          idxNext     = byteIdx + 1'b1;
          if (lastByte) begin
            stNext  = ST_STS;
            idxNext = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      byteIdx <= '0;
    end else begin
      st      <= stNext;
      byteIdx <= idxNext;
    end
  end

endmodule

// File: rtl/wpg_dpath.sv
`timescale 1ns/1ps
module wpg_dpath
  import wpg_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int BUSY_CYC   = 20,
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
  localparam int BLK_W = 8 * ADDR_BYTES,
  localparam int CNT_W = $clog2(BUSY_CYC + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wpN,
  input  wpg_strobe_t      stb,
  input  logic [IDX_W-1:0] byteIdx,
  input  logic [7:0]       ioIn,
  input  logic             stsMode,
  input  logic             rdEn,
  input  logic             opReq,
  input  logic [BLK_W-1:0] opBlk,
  output logic [7:0]       dataOut,
  output logic             ready,
  output logic             opGrant,
  output logic             tightFlag,
  output logic             rangeValid,
  output logic [BLK_W-1:0] rangeLo,
  output logic [BLK_W-1:0] rangeHi
);

  logic [BLK_W-1:0] loAcc, hiAcc, qryAcc, hiMerged;
  logic [CNT_W-1:0] busyCnt;
  logic             opOk, qryOk;
  logic [7:0]       stsByte;

  // address byte assembly, least significant byte first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loAcc  <= '0;
      hiAcc  <= '0;
      qryAcc <= '0;
    end else begin
      if (stb.loadLo)  loAcc[int'(byteIdx)*8 +: 8]  <= ioIn;
      if (stb.loadHi)  hiAcc[int'(byteIdx)*8 +: 8]  <= ioIn;
      if (stb.loadQry) qryAcc[int'(byteIdx)*8 +: 8] <= ioIn;
    end
  end

  // end address including the byte arriving in the commit cycle
  always_comb begin
    hiMerged = hiAcc;
    hiMerged[int'(byteIdx)*8 +: 8] = ioIn;
  end

  // protection state
  always_ff @(posedge clk) begin
    if (!rstN || !wpN) begin
      tightFlag  <= 1'b0;
      rangeValid <= 1'b0;
      rangeLo    <= '0;
      rangeHi    <= '0;
    end else begin
      if (stb.setTight) tightFlag <= 1'b1;
      if (stb.commit && !tightFlag && (loAcc <= hiMerged)) begin
        rangeValid <= 1'b1;
        rangeLo    <= loAcc;
        rangeHi    <= hiMerged;
      end
    end
  end

  assign opOk  = rangeValid && (opBlk >= rangeLo) && (opBlk <= rangeHi);
  assign qryOk = rangeValid && (qryAcc >= rangeLo) && (qryAcc <= rangeHi);

  // request arbitration and busy timer
  assign ready = (busyCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      opGrant <= 1'b0;
    end else begin
      opGrant <= 1'b0;
      if (!ready) begin
        busyCnt <= busyCnt - 1'b1;
      end else if (opReq) begin
        if (opOk) opGrant <= 1'b1;
        else      busyCnt <= CNT_W'(BUSY_CYC);
      end
    end
  end

  // live status byte
  always_comb begin
    if (qryOk)          stsByte = STS_UNLOCKED;
    else if (tightFlag) stsByte = STS_TIGHT;
    else                stsByte = STS_LOCKED;
  end

  assign dataOut = (stsMode && rdEn) ? stsByte : 8'h00;

endmodule

// File: rtl/flash_wp_guard.sv
`timescale 1ns/1ps
module flash_wp_guard
  import wpg_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int BUSY_CYC   = 20,
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
  localparam int BLK_W = 8 * ADDR_BYTES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdLatch,
  input  logic             addrLatch,
  input  logic [7:0]       ioIn,
  input  logic             rdEn,
  output logic [7:0]       dataOut,
  input  logic             opReq,
  input  logic [BLK_W-1:0] opBlk,
  output logic             opGrant,
  output logic             ready,
  input  logic             wpN
);

  wpg_strobe_t      stb;
  logic [IDX_W-1:0] byteIdx;
  logic             stsMode;
  logic             tightFlag;
  logic             rangeValid;
  logic [BLK_W-1:0] rangeLo, rangeHi;

  wpg_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdLatch (cmdLatch),
    .addrLatch(addrLatch),
    .ioIn     (ioIn),
    .ready    (ready),
    .stb      (stb),
    .byteIdx  (byteIdx),
    .stsMode  (stsMode)
  );

  wpg_dpath #(.ADDR_BYTES(ADDR_BYTES), .BUSY_CYC(BUSY_CYC)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .wpN       (wpN),
    .stb       (stb),
    .byteIdx   (byteIdx),
    .ioIn      (ioIn),
    .stsMode   (stsMode),
    .rdEn      (rdEn),
    .opReq     (opReq),
    .opBlk     (opBlk),
    .dataOut   (dataOut),
    .ready     (ready),
    .opGrant   (opGrant),
    .tightFlag (tightFlag),
    .rangeValid(rangeValid),
    .rangeLo   (rangeLo),
    .rangeHi   (rangeHi)
  );

endmodule

// File: rtl/wpg_checker.sv
`timescale 1ns/1ps
module wpg_checker #(
  parameter int ADDR_BYTES = 2,
  parameter int BUSY_CYC   = 20,
  localparam int BLK_W = 8 * ADDR_BYTES
) (
  input logic             clk,
  input logic             rstN,
  input logic             wpN,
  input logic             rdEn,
  input logic             opReq,
  input logic [BLK_W-1:0] opBlk,
  input logic             opGrant,
  input logic             ready,
  input logic [7:0]       dataOut,
  input logic             tightFlag,
  input logic             rangeValid,
  input logic [BLK_W-1:0] rangeLo,
  input logic [BLK_W-1:0] rangeHi
);

  logic inWin;
  int   lowCnt;

  assign inWin = rangeValid && (opBlk >= rangeLo) && (opBlk <= rangeHi);

  always_ff @(posedge clk) begin
    if (!rstN || ready) lowCnt <= 0;
    else                lowCnt <= lowCnt + 1;
  end

  p_range_ordered_r3: assert property (@(posedge clk) disable iff (!rstN)
    rangeValid |-> (rangeLo <= rangeHi));

  p_frozen_under_tight_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(tightFlag) && $past(wpN)) |-> ($stable(rangeLo) && $stable(rangeHi) && $stable(rangeValid)));

  p_tight_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(tightFlag) && $past(wpN)) |-> tightFlag);

  p_wp_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    !wpN |=> (!tightFlag && !rangeValid));

  p_grant_unlocked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && ready && inWin) |=> (opGrant && ready));

  p_reject_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && ready && !inWin) |=> (!ready && !opGrant));

  p_busy_bounded_r6: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= BUSY_CYC);

  p_status_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dataOut[7:3] == 5'd0) && $onehot0(dataOut));

  p_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (dataOut == 8'h00));

endmodule

bind flash_wp_guard wpg_checker #(.ADDR_BYTES(ADDR_BYTES), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wpN       (wpN),
  .rdEn      (rdEn),
  .opReq     (opReq),
  .opBlk     (opBlk),
  .opGrant   (opGrant),
  .ready     (ready),
  .dataOut   (dataOut),
  .tightFlag (tightFlag),
  .rangeValid(rangeValid),
  .rangeLo   (rangeLo),
  .rangeHi   (rangeHi)
);

// File: tb/flash_wp_guard_tb.sv
`timescale 1ns/1ps
module flash_wp_guard_tb;

  localparam int AB   = 2;
  localparam int BW   = 8 * AB;
  localparam int BUSY = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdLatch = 1'b0;
  logic          addrLatch = 1'b0;
  logic          rdEn = 1'b0;
  logic          opReq = 1'b0;
  logic          wpN = 1'b1;
  logic [7:0]    ioIn = 8'h00;
  logic [BW-1:0] opBlk = '0;
  wire  [7:0]    dataOut;
  wire           ready;
  wire           opGrant;

  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  flash_wp_guard #(.ADDR_BYTES(AB), .BUSY_CYC(BUSY)) u_dut (
    .clk(clk), .rstN(rstN), .cmdLatch(cmdLatch), .addrLatch(addrLatch),
    .ioIn(ioIn), .rdEn(rdEn), .dataOut(dataOut), .opReq(opReq),
    .opBlk(opBlk), .opGrant(opGrant), .ready(ready), .wpN(wpN)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sendCmd(logic [7:0] c);
    cmdLatch = 1'b1; ioIn = c;
    cyc();
    cmdLatch = 1'b0;
  endtask

  task automatic sendAddr(logic [BW-1:0] b);
    for (int i = 0; i < AB; i++) begin
      addrLatch = 1'b1; ioIn = b[i*8 +: 8];
      cyc();
    end
    addrLatch = 1'b0;
  endtask

  task automatic unlock(logic [BW-1:0] lo, logic [BW-1:0] hi);
    sendCmd(8'h23); sendAddr(lo); sendCmd(8'h24); sendAddr(hi);
  endtask

  task automatic readNow(output logic [7:0] s);
    rdEn = 1'b1; #1; s = dataOut; rdEn = 1'b0; #1;
  endtask

  task automatic query(logic [BW-1:0] b, output logic [7:0] s);
    sendCmd(8'h7A); sendAddr(b); readNow(s);
  endtask

  task automatic doOp(logic [BW-1:0] b, output logic g, output logic r);
    opReq = 1'b1; opBlk = b;
    cyc();
    opReq = 1'b0;
    g = opGrant; r = ready;
  endtask

  // counts the low cycles of ready, the first one already seen
  task automatic waitReady(output int n);
    n = 1;
    while (!ready && n < 1000) begin
      cyc();
      if (!ready) n++;
    end
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1", "ready", ready, 1);
    chk("R1", "opGrant", opGrant, 0);
    chk("R1", "dataOut", dataOut, 0);
    query(16'd5, s);
    chk("R1", "status blk5", s, 8'h02);
  endtask

  task automatic t_unlock_window();
    logic [7:0] s; logic g, r; int n;
    unlock(16'd10, 16'd20);
    query(16'd10, s); chk("R2", "lower edge", s, 8'h04);
    query(16'd20, s); chk("R2", "upper edge", s, 8'h04);
    query(16'd9,  s); chk("R2", "below window", s, 8'h02);
    query(16'd21, s); chk("R2", "above window", s, 8'h02);
    doOp(16'd15, g, r);
    chk("R6", "grant inside", g, 1);
    chk("R6", "ready after grant", r, 1);
    cyc();
    chk("R6", "grant is one pulse", opGrant, 0);
    doOp(16'd300, g, r);
    chk("R6", "no grant outside", g, 0);
    chk("R6", "busy after reject", r, 0);
    waitReady(n);
    chk("R6", "busy length", n, BUSY);
  endtask

  task automatic t_replace_single();
    logic [7:0] s; logic g, r; int n;
    sendCmd(8'h23); sendAddr(16'd100); sendCmd(8'h24);
    doOp(16'd15, g, r);
    chk("R2", "old window while sequence open", g, 1);
    addrLatch = 1'b1; ioIn = 8'd100; cyc();
    addrLatch = 1'b1; ioIn = 8'd0;   cyc();
    addrLatch = 1'b0;
    query(16'd100, s); chk("R3", "single block", s, 8'h04);
    query(16'd99,  s); chk("R3", "below single", s, 8'h02);
    query(16'd101, s); chk("R3", "above single", s, 8'h02);
    query(16'd15,  s); chk("R3", "old window replaced", s, 8'h02);
    doOp(16'd15, g, r);
    chk("R3", "old window rejects", g, 0);
    waitReady(n);
  endtask

  task automatic t_abort_and_reverse();
    logic [7:0] s;
    sendCmd(8'h23); sendAddr(16'd50); sendCmd(8'h00); sendCmd(8'h24); sendAddr(16'd60);
    query(16'd55, s); chk("R2", "aborted sequence", s, 8'h02);
    query(16'd100, s); chk("R2", "window kept after abort", s, 8'h04);
    unlock(16'd300, 16'd200);
    query(16'd250, s); chk("R3", "reversed pair ignored", s, 8'h02);
    query(16'd100, s); chk("R3", "window kept after reversed", s, 8'h04);
  endtask

  task automatic t_tight();
    logic [7:0] s; logic g, r;
    sendCmd(8'h2C);
    query(16'd5, s);   chk("R4", "locked becomes tight", s, 8'h01);
    query(16'd100, s); chk("R4", "unlocked stays", s, 8'h04);
    unlock(16'd0, 16'd4000);
    query(16'd5, s);   chk("R4", "unlock ignored", s, 8'h01);
    query(16'd100, s); chk("R4", "window unchanged", s, 8'h04);
    doOp(16'd100, g, r);
    chk("R4", "grant under tight", g, 1);
    sendCmd(8'hFF); sendCmd(8'h23);
    query(16'd5, s);   chk("R5", "commands keep tight", s, 8'h01);
  endtask

  task automatic t_wp_pulse();
    logic [7:0] s;
    wpN = 1'b0; cyc(); wpN = 1'b1;
    query(16'd5, s);   chk("R5", "tight released", s, 8'h02);
    query(16'd100, s); chk("R5", "window emptied", s, 8'h02);
  endtask

  task automatic t_persist();
    logic [7:0] s;
    unlock(16'd7, 16'd7);
    query(16'd7, s);  chk("R7", "query unlocked", s, 8'h04);
    #1; chk("R7", "no read strobe", dataOut, 0);
    readNow(s);        chk("R8", "repeat read", s, 8'h04);
    cyc(); readNow(s); chk("R8", "later read", s, 8'h04);
    wpN = 1'b0; cyc(); wpN = 1'b1;
    readNow(s);        chk("R8", "live update", s, 8'h02);
    sendCmd(8'hFF);
    readNow(s);        chk("R8", "other cmd exits", s, 8'h00);
  endtask

  task automatic t_busy_status();
    logic [7:0] s; logic g, r; int n;
    unlock(16'd40, 16'd45);
    doOp(16'd1000, g, r);
    chk("R6", "reject again", r, 0);
    doOp(16'd42, g, r);
    chk("R6", "ignored while busy", g, 0);
    query(16'd42, s);
    chk("R9", "status refused while busy", s, 8'h00);
    waitReady(n);
    query(16'd42, s);
    chk("R9", "status after ready", s, 8'h04);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    t_reset();
    t_unlock_window();
    t_replace_single();
    t_abort_and_reverse();
    t_tight();
    t_wp_pulse();
    t_persist();
    t_busy_status();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule